// File: doc/BRIEF.md
# Per-Core Event Timer with Wide Free-Running Counter

This block gives one processor core two time services behind a small synchronous register port. The first is a 56-bit cycle counter that starts at zero when reset is released and then advances on every clock, whatever software does. Software reads it as two 32-bit words. The low word is always the live value, so software can rebuild a consistent 56-bit value by reading the high word again until two reads match.

The second service is a one-shot event timer. Software writes a tick count to the load register and sets the enable bit. After that many clock ticks the block sets a pending flag and drives a level interrupt. The flag stays set until software clears it through the status register. The timer does not reload by itself. A fresh load write re-arms it, and a load write during a countdown restarts it from the new value.

The register port takes a write strobe, a register index and write data. Read data is combinational on the index and shows the state of the current cycle. Register indices: 0 control, 1 status, 2 counter high, 3 counter low, 4 load/remaining. Indices 5 to 7 are unused.

Top module: `evt_timer_core`

## Requirements
- R1: After reset is released the counter is 0 and increments by exactly one on every clock edge. Control, status and load writes never stop it or reload it.
- R2: A read of index 3 returns counter bits [31:0] of the current cycle. A read of index 2 returns counter bits [55:32] in bits [23:0], and bits [31:24] read as 0.
- R3: With enable set, a write of N (N ≠ 0) to index 4 sets the pending flag (status bit 0) on the Nth clock edge after the write edge.
- R4: A load write while a countdown is running restarts the countdown from the new value. A load write on the same edge where the old countdown would expire cancels that expiry.
- R5: After expiry the remaining count (read at index 4) is 0 and the armed flag (status bit 1) is 0. No further expiry occurs until the next load write.
- R6: Control bit 0 (index 0) enables the event timer. While it is 0 the remaining count holds and no expiry occurs. Setting it back to 1 resumes the countdown from where it stopped.
- R7: A status write (index 1) with bit 0 equal to 0 clears the pending flag. A write with bit 0 equal to 1 has no effect. An expiry on the same edge as a clear leaves the flag set.
- R8: The interrupt output equals the pending flag, a level that stays high until it is cleared.
- R9: Reset clears the counter, pending flag, armed flag, remaining count and enable. Every index then reads 0.
- R10: A load write of 0 disarms the timer without raising an event.
- R11: Reads of indices 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx, current cycle |
| evt_irq | output | 1 | Level event interrupt |

## Verification
The bench targets the expiry edge exactly. A countdown that is off by one in either direction shows the pending flag one cycle early or late. It also presents a status clear on the very edge where an expiry fires; a design that lets the clear win drops the interrupt. A reload just before expiry tests the restart rule, and a design that keeps the old expiry raises a spurious early event. Disabling mid-countdown checks that the remaining count freezes; a design that keeps counting fires while disabled or resumes from the wrong value. The counter words are compared every cycle, so a registered low word or nonzero padding in the high word is caught.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
   localparam int unsigned IDX_W    = 3;
   localparam logic [IDX_W-1:0] IX_CTRL = 3'd0;
   localparam logic [IDX_W-1:0] IX_STAT = 3'd1;
   localparam logic [IDX_W-1:0] IX_HIGH = 3'd2;
   localparam logic [IDX_W-1:0] IX_LOW  = 3'd3;
   localparam logic [IDX_W-1:0] IX_LOAD = 3'd4;
endpackage

// File: rtl/evt_freecount.sv
module evt_freecount #(
   parameter int unsigned CNT_W = 56
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/evt_oneshot.sv
module evt_oneshot #(
   parameter int unsigned DELTA_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_wr,
   input  logic               ctrl_en_val,
   input  logic               load_wr,
   input  logic [DELTA_W-1:0] load_val,
   input  logic               stat_clr,
   output logic               en_o,
   output logic               armed_o,
   output logic               pend_o,
   output logic [DELTA_W-1:0] remain_o
);
   logic               en_q, armed_q, pend_q, fire;
   logic [DELTA_W-1:0] remain_q;

   assign fire = en_q && armed_q && (remain_q == DELTA_W'(1)) && !load_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (ctrl_wr) en_q <= ctrl_en_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         armed_q  <= 1'b0;
      end else if (load_wr) begin
         remain_q <= load_val;
         armed_q  <= |load_val;
      end else if (en_q && armed_q) begin
         if (remain_q == DELTA_W'(1)) begin
            remain_q <= '0;
            armed_q  <= 1'b0;
         end else begin
            remain_q <= remain_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (fire)     pend_q <= 1'b1;
      else if (stat_clr) pend_q <= 1'b0;
   end

   assign en_o     = en_q;
   assign armed_o  = armed_q;
   assign pend_o   = pend_q;
   assign remain_o = remain_q;

   p_fire_sets_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> pend_q);
   p_idle_after_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (remain_q == '0) && !armed_q);
   p_freeze_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !load_wr) |=> $stable(remain_q));
   p_clear_drops_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !fire) |=> !pend_q);
   p_zero_load_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (load_wr && load_val == '0) |=> !armed_q && !pend_q || !armed_q);
endmodule

// File: rtl/evt_regread.sv
module evt_regread #(
   parameter int unsigned CNT_W   = 56,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              en,
   input  logic              armed,
   input  logic              pend,
   input  logic [DATA_W-1:0] remain,
   output logic [DATA_W-1:0] rdata
);
   import evt_timer_pkg::*;
   localparam int unsigned HI_W = CNT_W - DATA_W;

   logic [DATA_W-1:0] hi_word;

   generate
      if (HI_W == DATA_W) begin : g_hi_full
         assign hi_word = cnt[CNT_W-1:DATA_W];
      end else begin : g_hi_pad
         assign hi_word = {{(DATA_W-HI_W){1'b0}}, cnt[CNT_W-1:DATA_W]};
      end
   endgenerate

   always_comb begin
      rdata = '0;
      unique case (idx)
         IX_CTRL: rdata[0]   = en;
         IX_STAT: rdata[1:0] = {armed, pend};
         IX_HIGH: rdata      = hi_word;
         IX_LOW:  rdata      = cnt[DATA_W-1:0];
         IX_LOAD: rdata      = remain;
         default: rdata      = '0;
      endcase
   end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
   parameter int unsigned CNT_W  = 56,
   parameter int unsigned DATA_W = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             reg_wr,
   input  logic [evt_timer_pkg::IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0]                reg_wdata,
   output logic [DATA_W-1:0]                reg_rdata,
   output logic                             evt_irq
);
   import evt_timer_pkg::*;

   generate
      if (CNT_W <= DATA_W || CNT_W > 2 * DATA_W) begin : g_bad_width
         $error("CNT_W must lie in (DATA_W, 2*DATA_W]");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt;
   logic              en, armed, pend;
   logic [DATA_W-1:0] remain;
   logic              ctrl_wr, load_wr, stat_clr;

   assign ctrl_wr  = reg_wr && (reg_idx == IX_CTRL);
   assign load_wr  = reg_wr && (reg_idx == IX_LOAD);
   assign stat_clr = reg_wr && (reg_idx == IX_STAT) && !reg_wdata[0];

   evt_freecount #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .cnt_o(cnt)
   );

   evt_oneshot #(.DELTA_W(DATA_W)) u_shot (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr(ctrl_wr), .ctrl_en_val(reg_wdata[0]),
      .load_wr(load_wr), .load_val(reg_wdata),
      .stat_clr(stat_clr),
      .en_o(en), .armed_o(armed), .pend_o(pend), .remain_o(remain)
   );

   evt_regread #(.CNT_W(CNT_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_read (
      .idx(reg_idx), .cnt(cnt), .en(en), .armed(armed), .pend(pend),
      .remain(remain), .rdata(reg_rdata)
   );

   assign evt_irq = pend;

   p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_irq && !stat_clr) |=> evt_irq);
endmodule

// File: tb/evt_timer_core_tb_top.sv
module evt_timer_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_idx = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        evt_irq;

   int    n_vec = 0;
   int    n_bad = 0;
   string cur_req = "R9";
   bit    finished = 1'b0;

   longint unsigned m_cnt = 0;
   longint unsigned m_rem = 0;
   bit m_arm = 0, m_pend = 0, m_en = 0;

   always #2.5 clk = ~clk;

   evt_timer_core dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_irq(evt_irq)
   );

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      bit fire, ld;
      if (!rst_n) begin
         m_cnt = 0; m_rem = 0; m_arm = 0; m_pend = 0; m_en = 0;
      end else begin
         ld   = reg_wr && reg_idx == 3'd4;
         fire = m_en && m_arm && m_rem == 1 && !ld;
         m_cnt = (m_cnt + 1) & 64'h00FF_FFFF_FFFF_FFFF;
         if (ld) begin
            m_rem = reg_wdata; m_arm = (reg_wdata != 0);
         end else if (m_en && m_arm) begin
            m_rem = m_rem - 1;
            if (m_rem == 0) m_arm = 0;
         end
         if (fire) m_pend = 1;
         else if (reg_wr && reg_idx == 3'd1 && !reg_wdata[0]) m_pend = 0;
         if (reg_wr && reg_idx == 3'd0) m_en = reg_wdata[0];
      end
   end

   function automatic logic [31:0] expect_rd(input logic [2:0] ix);
      case (ix)
         3'd0: return {31'd0, m_en};
         3'd1: return {30'd0, m_arm, m_pend};
         3'd2: return {8'd0, m_cnt[55:32]};
         3'd3: return m_cnt[31:0];
         3'd4: return m_rem[31:0];
         default: return 32'd0;
      endcase
   endfunction

   task automatic cyc(input bit w, input logic [2:0] ix, input logic [31:0] d);
      logic [31:0] e;
      @(negedge clk);
      e = expect_rd(reg_idx);
      n_vec++;
      if (reg_rdata !== e) begin
         n_bad++;
         $display("FAIL %s: idx %0d rdata=%h expected %h", cur_req, reg_idx, reg_rdata, e);
      end
      n_vec++;
      if (evt_irq !== m_pend) begin
         n_bad++;
         $display("FAIL %s: irq=%b expected %b (R8)", cur_req, evt_irq, m_pend);
      end
      reg_wr = w; reg_idx = ix; reg_wdata = d;
   endtask

   task automatic idle(input int n, input logic [2:0] ix);
      for (int i = 0; i < n; i++) cyc(0, ix, 0);
   endtask

   initial begin
      // R9: reset state on every index
      for (int i = 0; i < 8; i++) cyc(0, 3'(i), 0);
      @(negedge clk); rst_n = 1'b1;
      cur_req = "R1"; idle(20, 3'd3);
      cur_req = "R2"; idle(4, 3'd2); idle(4, 3'd3);
      cur_req = "R11"; idle(1, 3'd5); idle(1, 3'd6); idle(1, 3'd7);
      cur_req = "R3";
      cyc(1, 3'd0, 32'd1);
      cyc(1, 3'd4, 32'd5);
      idle(8, 3'd1);
      cur_req = "R8"; idle(5, 3'd1);
      cur_req = "R7"; cyc(1, 3'd1, 32'd1); idle(2, 3'd1);
      cyc(1, 3'd1, 32'd0); idle(2, 3'd1);
      cur_req = "R5"; idle(3, 3'd4); idle(10, 3'd1);
      cur_req = "R4";
      cyc(1, 3'd4, 32'd10); idle(4, 3'd4);
      cyc(1, 3'd4, 32'd3); idle(6, 3'd1);
      cyc(1, 3'd1, 32'd0);
      cyc(1, 3'd4, 32'd2); cyc(0, 3'd1, 0);
      cyc(1, 3'd4, 32'd4); idle(7, 3'd1);
      cur_req = "R6";
      cyc(1, 3'd1, 32'd0);
      cyc(1, 3'd4, 32'd6); idle(2, 3'd4);
      cyc(1, 3'd0, 32'd0); idle(10, 3'd4); idle(2, 3'd1);
      cyc(1, 3'd0, 32'd1); idle(8, 3'd4); idle(2, 3'd1);
      cur_req = "R7";
      cyc(1, 3'd4, 32'd3); idle(2, 3'd1);
      cyc(1, 3'd1, 32'd0); idle(3, 3'd1);
      cyc(1, 3'd1, 32'd0); idle(2, 3'd1);
      cur_req = "R10";
      cyc(1, 3'd4, 32'd5); idle(2, 3'd4);
      cyc(1, 3'd4, 32'd0); idle(8, 3'd1); idle(2, 3'd4);
      cur_req = "R1"; idle(6, 3'd3); idle(2, 3'd2);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule